// File: doc/BRIEF.md
# DMA Buffer Descriptor Sequencer

This block is one DMA channel that runs from buffer descriptors held in byte-wide memory. A start-with-autoload command points the channel at an initial descriptor address. The channel reads the descriptor fields it needs, one byte per bus beat, and then moves data one byte at a time. Each byte is a read from the source followed by a write to the destination. Moves are paced by a channel request input. A descriptor finishes when its byte count runs out or when a masked match on the data byte ends it early. The channel then stops or goes on to the next descriptor. The next descriptor is either the adjacent 12-byte record or the record at a link address.

All traffic uses one request/acknowledge port. The port carries a 24-bit address, a write flag and a 2-bit space tag. A beat completes in the cycle where the acknowledge is seen while the request is high. Software sees progress through status outputs:
- a state code,
- the count of bytes left unused in the last descriptor,
- a counter of descriptors started,
- a one-cycle interrupt pulse.

A halt command freezes the channel. A register-start command resumes moving data from the registers already loaded, without reading a descriptor.

Top module: `dma_seq_top`

## Requirements
- R1: After reset the state code is 0xFE, no bus request is made, the interrupt is low, and the unused count and the descriptor counter are zero. The state code 0xFE (idle) always comes with no bus request.
- R2: A start-with-autoload pulse sets the descriptor counter to 0xFF and begins reading at initial address + 1, with state code 0xFC. Byte 0 (status) is never read. The counter increments when the upper length byte (offset 3) is read.
- R3: The control byte holds the field modes: bits 3:2 for the source and bits 1:0 for the destination. The mode codes are 00 internal I/O (fixed), 01 external I/O (fixed), 10 memory with decrement and 11 memory with increment. A memory address is read from offsets 4..6 or 8..10. An I/O address reads only the first two of those bytes, and its bits 23:16 are zero. Space tag: 0 memory, 1 internal I/O, 2 external I/O; descriptor reads use tag 0.
- R4: When control bit 6 is set, the link address is read from offsets 12..14 and the next descriptor starts there. Otherwise the next descriptor starts at the current descriptor address + 12. Offsets 7, 11 and 15 are never read.
- R5: The state code during descriptor reads is as follows:
  - control byte: 0xFC on the first descriptor, 0xFA on a chained descriptor
  - length bytes: 0xF4, 0xF2
  - source bytes: 0xEE, 0xEC, 0xEA
  - destination bytes: 0xDE, 0xDC, 0xDA
  - link bytes: 0xBE, 0xBC, 0xBA
- R6: During data movement the state code is 0x7E. Each byte is a source read followed by a destination write of the same value. A source read is requested only while the channel request is high. After each write, memory addresses step by +1 or -1 according to their mode, and I/O addresses stay fixed. A pending request holds its address until acknowledged.
- R7: The length counts down once per moved byte. A loaded length of 0 means 65536 bytes.
- R8: A descriptor ends after writing a byte whose value satisfies ((byte XOR term) AND mask) == 0. A zero mask disables matching.
- R9: When a descriptor ends, the unused count takes the remaining length: 0 after a full count, nonzero after an early end.
- R10: Control bit 4 makes the interrupt pulse for one cycle, in the cycle after the last write of the descriptor. Control bit 7 returns the channel to idle after that descriptor; otherwise it chains.
- R11: A halt pulse returns the channel to idle on the next cycle, and it overrides any start given in the same cycle. A register-start pulse enters data movement (0x7E) on the next cycle with no descriptor reads and leaves the descriptor counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startLoad | input | 1 | Start with descriptor autoload |
| startRegs | input | 1 | Resume from loaded registers |
| halt | input | 1 | Freeze channel |
| chanReq | input | 1 | Channel transfer request |
| initAddr | input | 24 | First descriptor address |
| termByte | input | 8 | Termination compare value |
| termMask | input | 8 | Termination compare mask |
| busReq | output | 1 | Bus beat request |
| busWe | output | 1 | Beat is a write |
| busSpace | output | 2 | Address space tag |
| busAddr | output | 24 | Beat address |
| busWrData | output | 8 | Write data |
| busRdData | input | 8 | Read data, valid with acknowledge |
| busAck | input | 1 | Beat acknowledge |
| stateCode | output | 8 | Sequencer state code |
| unusedCount | output | 16 | Length left when last descriptor ended |
| bufDoneCount | output | 8 | Descriptor counter |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Each bus beat finishes in the cycle where the acknowledge meets a raised request. The state code and address are checked against a queued expectation at the falling edge of that same cycle. The interrupt is due one cycle after the acknowledge of the final write. It is counted at falling edges and compared once the channel is idle again. The unused count and descriptor counter are registered on that final acknowledge and are read only after idle. Halt and register-start results are due one cycle after the pulse and are sampled at the next falling edge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int ADDR_W     = 24;
  localparam int DATA_W     = 8;
  localparam int LEN_W      = 16;
  localparam int CNT_W      = 8;
  localparam int OFS_W      = 4;
  localparam int DESC_SHORT = 12;

  localparam logic [1:0] SP_MEM = 2'd0;
  localparam logic [1:0] SP_INT = 2'd1;
  localparam logic [1:0] SP_EXT = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_LEN0, ST_LEN1, ST_SRC0, ST_SRC1, ST_SRC2,
    ST_DST0, ST_DST1, ST_DST2, ST_LNK0, ST_LNK1, ST_LNK2, ST_RD, ST_WR
  } seqState_e;

  typedef enum logic [1:0] { SEL_DESC, SEL_SRC, SEL_DST } busSel_e;

  typedef struct packed {
    logic       isFinal;
    logic       useLink;
    logic       irqEn;
    logic [1:0] srcMode;
    logic [1:0] dstMode;
  } descCtl_t;

  typedef struct packed {
    logic             startLoad;
    logic             capEn;
    logic [OFS_W-1:0] capOfs;
    busSel_e          busSel;
    logic             dataCap;
    logic             byteMoved;
    logic             descDone;
    logic             chainNext;
  } seqStrb_t;

  function automatic logic [1:0] spaceOf(logic [1:0] mode);
    case (mode)
      2'b00:   return SP_INT;
      2'b01:   return SP_EXT;
      default: return SP_MEM;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [DATA_W-1:0] termByte,
  input  logic [DATA_W-1:0] termMask,
  input  logic [DATA_W-1:0] busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSpace,
  output logic [DATA_W-1:0] busWrData,
  output descCtl_t          descCtl,
  output logic              endHere,
  output logic [LEN_W-1:0]  unusedCount,
  output logic [CNT_W-1:0]  bufDoneCount
);
  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] descPtr, srcAddr, dstAddr, linkAddr;
  logic [LEN_W-1:0]  lenReg;
  logic [DATA_W-1:0] dataReg;
  logic              matchHit;

  function automatic logic [ADDR_W-1:0] stepAddr(logic [ADDR_W-1:0] a, logic [1:0] mode);
    if (!mode[1]) return a;
    return mode[0] ? a + 1'b1 : a - 1'b1;
  endfunction

  assign matchHit  = (termMask != '0) && (((dataReg ^ termByte) & termMask) == '0);
  assign endHere   = matchHit || (lenReg == LEN_W'(1));
  assign busWrData = dataReg;

  always_comb begin
    case (strb.busSel)
      SEL_SRC: begin busAddr = srcAddr; busSpace = spaceOf(descCtl.srcMode); end
      SEL_DST: begin busAddr = dstAddr; busSpace = spaceOf(descCtl.dstMode); end
      default: begin busAddr = descPtr + ADDR_W'(strb.capOfs); busSpace = SP_MEM; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr <= '0; srcAddr <= '0; dstAddr <= '0; linkAddr <= '0;
      lenReg <= '0; dataReg <= '0; descCtl <= '0;
      unusedCount <= '0; bufDoneCount <= '0;
    end else begin
      if (strb.startLoad) begin
        descPtr      <= initAddr;
        bufDoneCount <= '1;
      end
      if (strb.capEn) begin
        case (strb.capOfs)
          4'd1:  descCtl <= descCtl_t'({busRdData[7:6], busRdData[4:0]});
          4'd2:  lenReg[7:0]  <= busRdData;
          4'd3:  begin lenReg[15:8] <= busRdData; bufDoneCount <= bufDoneCount + 1'b1; end
          4'd4:  srcAddr <= {{PAD_W{1'b0}}, busRdData};
          4'd5:  srcAddr[15:8]  <= busRdData;
          4'd6:  srcAddr[23:16] <= busRdData;
          4'd8:  dstAddr <= {{PAD_W{1'b0}}, busRdData};
          4'd9:  dstAddr[15:8]  <= busRdData;
          4'd10: dstAddr[23:16] <= busRdData;
          4'd12: linkAddr <= {{PAD_W{1'b0}}, busRdData};
          4'd13: linkAddr[15:8]  <= busRdData;
          4'd14: linkAddr[23:16] <= busRdData;
          default: ;
        endcase
      end
      if (strb.dataCap) dataReg <= busRdData;
      if (strb.byteMoved) begin
        lenReg  <= lenReg - 1'b1;
        srcAddr <= stepAddr(srcAddr, descCtl.srcMode);
        dstAddr <= stepAddr(dstAddr, descCtl.dstMode);
      end
      if (strb.descDone) unusedCount <= lenReg - 1'b1;
      if (strb.chainNext)
        descPtr <= descCtl.useLink ? linkAddr : descPtr + ADDR_W'(DESC_SHORT);
    end
  end
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startLoad,
  input  logic       startRegs,
  input  logic       halt,
  input  logic       chanReq,
  input  logic       busAck,
  input  descCtl_t   descCtl,
  input  logic       endHere,
  output seqStrb_t   strb,
  output logic       busReq,
  output logic       busWe,
  output logic [7:0] stateCode,
  output logic       irq
);
  seqState_e state, nxt;
  logic      chainPhase;
  logic      ackOk;
  logic      isFetch;
  seqState_e afterDst;

  function automatic logic [OFS_W-1:0] ofsOf(seqState_e s);
    case (s)
      ST_CTRL: return 4'd1;  ST_LEN0: return 4'd2;  ST_LEN1: return 4'd3;
      ST_SRC0: return 4'd4;  ST_SRC1: return 4'd5;  ST_SRC2: return 4'd6;
      ST_DST0: return 4'd8;  ST_DST1: return 4'd9;  ST_DST2: return 4'd10;
      ST_LNK0: return 4'd12; ST_LNK1: return 4'd13; ST_LNK2: return 4'd14;
      default: return 4'd0;
    endcase
  endfunction

  always_comb begin
    case (state)
      ST_CTRL: stateCode = chainPhase ? 8'hFA : 8'hFC;
      ST_LEN0: stateCode = 8'hF4;
      ST_LEN1: stateCode = 8'hF2;
      ST_SRC0: stateCode = 8'hEE;
      ST_SRC1: stateCode = 8'hEC;
      ST_SRC2: stateCode = 8'hEA;
      ST_DST0: stateCode = 8'hDE;
      ST_DST1: stateCode = 8'hDC;
      ST_DST2: stateCode = 8'hDA;
      ST_LNK0: stateCode = 8'hBE;
      ST_LNK1: stateCode = 8'hBC;
      ST_LNK2: stateCode = 8'hBA;
      ST_RD, ST_WR: stateCode = 8'h7E;
      default: stateCode = 8'hFE;
    endcase
  end

  assign isFetch  = (state != ST_IDLE) && (state != ST_RD) && (state != ST_WR);
  assign afterDst = descCtl.useLink ? ST_LNK0 : ST_RD;

  always_comb begin
    strb        = '0;
    strb.capOfs = ofsOf(state);
    busReq      = isFetch;
    busWe       = 1'b0;
    if (state == ST_RD) begin strb.busSel = SEL_SRC; busReq = chanReq; end
    if (state == ST_WR) begin strb.busSel = SEL_DST; busReq = 1'b1; busWe = 1'b1; end
    ackOk = busAck && busReq && !halt && !startLoad && !startRegs;
    nxt   = state;
    if (ackOk) begin
      strb.capEn = isFetch;
      case (state)
        ST_CTRL: nxt = ST_LEN0;
        ST_LEN0: nxt = ST_LEN1;
        ST_LEN1: nxt = ST_SRC0;
        ST_SRC0: nxt = ST_SRC1;
        ST_SRC1: nxt = descCtl.srcMode[1] ? ST_SRC2 : ST_DST0;
        ST_SRC2: nxt = ST_DST0;
        ST_DST0: nxt = ST_DST1;
        ST_DST1: nxt = descCtl.dstMode[1] ? ST_DST2 : afterDst;
        ST_DST2: nxt = afterDst;
        ST_LNK0: nxt = ST_LNK1;
        ST_LNK1: nxt = ST_LNK2;
        ST_LNK2: nxt = ST_RD;
        ST_RD: begin strb.dataCap = 1'b1; nxt = ST_WR; end
        ST_WR: begin
          strb.byteMoved = 1'b1;
          if (endHere) begin
            strb.descDone = 1'b1;
            if (descCtl.isFinal) nxt = ST_IDLE;
            else begin strb.chainNext = 1'b1; nxt = ST_CTRL; end
          end else nxt = ST_RD;
        end
        default: nxt = state;
      endcase
    end
    if (halt) nxt = ST_IDLE;
    else if (startLoad) begin nxt = ST_CTRL; strb.startLoad = 1'b1; end
    else if (startRegs) nxt = ST_RD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      chainPhase <= 1'b0;
      irq        <= 1'b0;
    end else begin
      state <= nxt;
      irq   <= ackOk && (state == ST_WR) && endHere && descCtl.irqEn;
      if (strb.startLoad) chainPhase <= 1'b0;
      else if (strb.chainNext) chainPhase <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startLoad,
  input  logic              startRegs,
  input  logic              halt,
  input  logic              chanReq,
  input  logic [ADDR_W-1:0] initAddr,
  input  logic [DATA_W-1:0] termByte,
  input  logic [DATA_W-1:0] termMask,
  output logic              busReq,
  output logic              busWe,
  output logic [1:0]        busSpace,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              busAck,
  output logic [7:0]        stateCode,
  output logic [LEN_W-1:0]  unusedCount,
  output logic [CNT_W-1:0]  bufDoneCount,
  output logic              irq
);
  seqStrb_t strb;
  descCtl_t descCtl;
  logic     endHere;

  dma_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .startRegs(startRegs),
    .halt(halt), .chanReq(chanReq), .busAck(busAck), .descCtl(descCtl),
    .endHere(endHere), .strb(strb), .busReq(busReq), .busWe(busWe),
    .stateCode(stateCode), .irq(irq)
  );

  dma_seq_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .initAddr(initAddr),
    .termByte(termByte), .termMask(termMask), .busRdData(busRdData),
    .busAddr(busAddr), .busSpace(busSpace), .busWrData(busWrData),
    .descCtl(descCtl), .endHere(endHere), .unusedCount(unusedCount),
    .bufDoneCount(bufDoneCount)
  );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startLoad,
  input logic        startRegs,
  input logic        halt,
  input logic        busReq,
  input logic        busAck,
  input logic        busWe,
  input logic [23:0] busAddr,
  input logic [7:0]  stateCode,
  input logic [7:0]  bufDoneCount,
  input logic        irq
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 8'hFE) |-> !busReq);

  p_load_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startLoad && !halt) |=> (bufDoneCount == 8'hFF && stateCode == 8'hFC));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !halt && !startLoad && !startRegs &&
     (busWe || stateCode != 8'h7E)) |=> (busReq && $stable(busAddr)));

  p_write_in_xfer_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe) |-> (stateCode == 8'h7E));

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  p_halt_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    halt |=> (stateCode == 8'hFE && !busReq));

  p_regs_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (startRegs && !halt && !startLoad) |=> (stateCode == 8'h7E && $stable(bufDoneCount)));
endmodule

bind dma_seq_top dma_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .startLoad(startLoad), .startRegs(startRegs),
  .halt(halt), .busReq(busReq), .busAck(busAck), .busWe(busWe),
  .busAddr(busAddr), .stateCode(stateCode), .bufDoneCount(bufDoneCount),
  .irq(irq)
);

// File: tb/dma_seq_top_tb_top.sv
`timescale 1ns/1ps
module dma_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startLoad = 1'b0, startRegs = 1'b0, halt = 1'b0, chanReq = 1'b1;
  logic [23:0] initAddr = '0;
  logic [7:0]  termByte = '0, termMask = '0;
  logic        busReq, busWe, busAck, irq;
  logic [1:0]  busSpace;
  logic [23:0] busAddr;
  logic [7:0]  busWrData, busRdData, stateCode, bufDoneCount;
  logic [15:0] unusedCount;

  always #2.5 clk = ~clk;

  dma_seq_top dut_i (
    .clk(clk), .rstN(rstN), .startLoad(startLoad), .startRegs(startRegs),
    .halt(halt), .chanReq(chanReq), .initAddr(initAddr), .termByte(termByte),
    .termMask(termMask), .busReq(busReq), .busWe(busWe), .busSpace(busSpace),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .busAck(busAck), .stateCode(stateCode), .unusedCount(unusedCount),
    .bufDoneCount(bufDoneCount), .irq(irq)
  );

  int nTests = 0, nFail = 0, irqCnt = 0;
  logic [7:0] mem [0:1023];

  typedef struct {
    logic we; logic [1:0] sp; logic [23:0] addr; logic [7:0] data; logic [7:0] code; string tag;
  } beat_t;
  beat_t expQ[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus responder: one-cycle acknowledge, byte memory and I/O pattern
  always @(posedge clk) begin
    if (!rstN) busAck <= 1'b0;
    else begin
      busAck <= busReq && !busAck;
      if (busReq && !busAck)
        busRdData <= (busSpace == 2'd0) ? mem[busAddr[9:0]] : (busAddr[7:0] ^ 8'hA5);
      if (busAck && busReq && busWe && busSpace == 2'd0 && !halt)
        mem[busAddr[9:0]] = busWrData;
    end
  end

  // monitor: compare each completed beat with the scoreboard
  always @(negedge clk) begin
    if (rstN && irq) irqCnt++;
    if (rstN && busAck && busReq && !halt && !startLoad && !startRegs) begin
      if (expQ.size() == 0) chk(1'b0, "R6 unexpected beat", {7'd0, busWe, busAddr}, 32'd0);
      else begin
        beat_t e;
        e = expQ.pop_front();
        chk(busWe == e.we && busSpace == e.sp && busAddr == e.addr && stateCode == e.code &&
            (!e.we || busWrData == e.data), e.tag,
            {busSpace, busWe, busAddr[12:0], stateCode, (busWe ? busWrData : 8'h00)},
            {e.sp, e.we, e.addr[12:0], e.code, (e.we ? e.data : 8'h00)});
      end
    end
  end

  task automatic pushRd(input logic [1:0] sp, input logic [23:0] a, input logic [7:0] code, input string tag);
    beat_t b; b.we = 0; b.sp = sp; b.addr = a; b.data = 0; b.code = code; b.tag = tag;
    expQ.push_back(b);
  endtask

  task automatic pushWr(input logic [1:0] sp, input logic [23:0] a, input logic [7:0] d, input string tag);
    beat_t b; b.we = 1; b.sp = sp; b.addr = a; b.data = d; b.code = 8'h7E; b.tag = tag;
    expQ.push_back(b);
  endtask

  task automatic putDesc(input int base, input logic [7:0] c, input logic [15:0] len,
                         input logic [23:0] s, input logic [23:0] d, input logic [23:0] l);
    mem[base] = 8'hEE; mem[base+1] = c; mem[base+2] = len[7:0]; mem[base+3] = len[15:8];
    mem[base+4] = s[7:0]; mem[base+5] = s[15:8]; mem[base+6] = s[23:16]; mem[base+7] = 8'h5C;
    mem[base+8] = d[7:0]; mem[base+9] = d[15:8]; mem[base+10] = d[23:16]; mem[base+11] = 8'h5C;
    mem[base+12] = l[7:0]; mem[base+13] = l[15:8]; mem[base+14] = l[23:16]; mem[base+15] = 8'h5C;
  endtask

  // expected descriptor reads (R2 R3 R4 R5)
  task automatic expFetch(input int base, input logic [7:0] c, input bit chained);
    pushRd(0, base+1, chained ? 8'hFA : 8'hFC, "R2 R4 R5 ctrl");
    pushRd(0, base+2, 8'hF4, "R5 len");
    pushRd(0, base+3, 8'hF2, "R5 len");
    pushRd(0, base+4, 8'hEE, "R3 R5 src");
    pushRd(0, base+5, 8'hEC, "R3 R5 src");
    if (c[3]) pushRd(0, base+6, 8'hEA, "R3 R5 src");
    pushRd(0, base+8, 8'hDE, "R3 R5 dst");
    pushRd(0, base+9, 8'hDC, "R3 R5 dst");
    if (c[1]) pushRd(0, base+10, 8'hDA, "R3 R5 dst");
    if (c[6]) begin
      pushRd(0, base+12, 8'hBE, "R4 R5 link");
      pushRd(0, base+13, 8'hBC, "R4 R5 link");
      pushRd(0, base+14, 8'hBA, "R4 R5 link");
    end
  endtask

  task automatic expMove(input logic [1:0] ss, input logic [23:0] sa, input logic [1:0] ds, input logic [23:0] da);
    logic [7:0] d;
    d = (ss == 0) ? mem[sa[9:0]] : (sa[7:0] ^ 8'hA5);
    pushRd(ss, sa, 8'h7E, "R6 src read");
    pushWr(ds, da, d, "R6 dst write");
  endtask

  task automatic pulseLoad(input logic [23:0] a);
    @(negedge clk); initAddr = a; startLoad = 1;
    @(negedge clk); startLoad = 0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (stateCode != 8'hFE && n < 5000) begin @(negedge clk); n++; end
    chk(stateCode == 8'hFE, tag, stateCode, 8'hFE);
    @(negedge clk);
    chk(expQ.size() == 0, {tag, " beats left"}, expQ.size(), 0);
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++; nTests++;
      $display("FAIL watchdog R6 actual=hung expected=idle");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int i0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(stateCode == 8'hFE && !busReq && !irq, "R1 reset idle", {stateCode, busReq, irq}, {8'hFE, 2'b00});
    chk(unusedCount == 0 && bufDoneCount == 0, "R1 reset counters", {unusedCount, bufDoneCount}, 0);

    // single descriptor, memory to memory increment, final + irq (R2 R10)
    putDesc(12'h100, 8'h9F, 16'd4, 24'h200, 24'h300, 24'h0);
    irqCnt = 0;
    expFetch(12'h100, 8'h9F, 0);
    for (int i = 0; i < 4; i++) expMove(0, 24'h200 + i, 0, 24'h300 + i);
    pulseLoad(24'h100);
    waitIdle("R10 single final");
    chk(bufDoneCount == 8'h00, "R2 counter after one length", bufDoneCount, 8'h00);
    chk(unusedCount == 0, "R9 full count", unusedCount, 0);
    chk(irqCnt == 1, "R10 irq pulse", irqCnt, 1);

    // linked chain: mem decrement -> ext io; int io -> mem (R3 R4)
    putDesc(12'h140, 8'h49, 16'd3, 24'h000220, 24'h770055, 24'h000180);
    putDesc(12'h180, 8'h93, 16'd2, 24'h990033, 24'h000320, 24'h0);
    irqCnt = 0;
    expFetch(12'h140, 8'h49, 0);
    for (int i = 0; i < 3; i++) expMove(0, 24'h220 - i, 2, 24'h000055);
    expFetch(12'h180, 8'h93, 1);
    for (int i = 0; i < 2; i++) expMove(1, 24'h000033, 0, 24'h320 + i);
    pulseLoad(24'h140);
    waitIdle("R4 linked chain");
    chk(bufDoneCount == 8'h01, "R2 counter two lengths", bufDoneCount, 8'h01);
    chk(irqCnt == 1, "R10 irq only on enabled descriptor", irqCnt, 1);

    // adjacent array, next at +12 (R4)
    putDesc(12'h1C0, 8'h0F, 16'd1, 24'h240, 24'h340, 24'h0);
    putDesc(12'h1CC, 8'h9F, 16'd2, 24'h241, 24'h341, 24'h0);
    expFetch(12'h1C0, 8'h0F, 0);
    expMove(0, 24'h240, 0, 24'h340);
    expFetch(12'h1CC, 8'h9F, 1);
    for (int i = 0; i < 2; i++) expMove(0, 24'h241 + i, 0, 24'h341 + i);
    pulseLoad(24'h1C0);
    waitIdle("R4 adjacent array");
    chk(bufDoneCount == 8'h01, "R4 counter array", bufDoneCount, 8'h01);

    // masked early termination (R8 R9)
    mem[12'h260] = 8'h11; mem[12'h261] = 8'h22; mem[12'h262] = 8'h45; mem[12'h263] = 8'h66;
    termByte = 8'h40; termMask = 8'hF0;
    putDesc(12'h100, 8'h9F, 16'd8, 24'h260, 24'h360, 24'h0);
    expFetch(12'h100, 8'h9F, 0);
    for (int i = 0; i < 3; i++) expMove(0, 24'h260 + i, 0, 24'h360 + i);
    pulseLoad(24'h100);
    waitIdle("R8 masked match");
    chk(unusedCount == 16'd5, "R9 early end unused", unusedCount, 5);

    // zero mask disables matching (R8)
    termByte = 8'h45; termMask = 8'h00;
    putDesc(12'h100, 8'h9F, 16'd4, 24'h260, 24'h380, 24'h0);
    expFetch(12'h100, 8'h9F, 0);
    for (int i = 0; i < 4; i++) expMove(0, 24'h260 + i, 0, 24'h380 + i);
    pulseLoad(24'h100);
    waitIdle("R8 zero mask");
    chk(unusedCount == 0, "R8 zero mask full count", unusedCount, 0);

    // length zero means 65536 (R7)
    mem[12'h270] = 8'h01; mem[12'h271] = 8'h02; mem[12'h272] = 8'h33;
    termByte = 8'h33; termMask = 8'hFF;
    putDesc(12'h100, 8'h9F, 16'd0, 24'h270, 24'h3A0, 24'h0);
    expFetch(12'h100, 8'h9F, 0);
    for (int i = 0; i < 3; i++) expMove(0, 24'h270 + i, 0, 24'h3A0 + i);
    pulseLoad(24'h100);
    waitIdle("R7 zero length");
    chk(unusedCount == 16'hFFFD, "R7 65536 minus three", unusedCount, 16'hFFFD);

    // request gating, halt, register start (R6 R11)
    termMask = 8'h00; chanReq = 0; irqCnt = 0;
    putDesc(12'h100, 8'h9F, 16'd3, 24'h280, 24'h390, 24'h0);
    expFetch(12'h100, 8'h9F, 0);
    pulseLoad(24'h100);
    i0 = 0;
    while (stateCode != 8'h7E && i0 < 200) begin @(negedge clk); i0++; end
    repeat (5) begin
      @(negedge clk);
      chk(!busReq && stateCode == 8'h7E, "R6 no read without request", {stateCode, busReq}, {8'h7E, 1'b0});
    end
    @(negedge clk); halt = 1;
    @(negedge clk); halt = 0;
    chk(stateCode == 8'hFE, "R11 halt to idle", stateCode, 8'hFE);
    chanReq = 1;
    repeat (8) @(negedge clk);
    chk(!busReq && stateCode == 8'hFE, "R11 halted stays idle", {stateCode, busReq}, {8'hFE, 1'b0});
    for (int i = 0; i < 3; i++) expMove(0, 24'h280 + i, 0, 24'h390 + i);
    startRegs = 1;
    @(negedge clk); startRegs = 0;
    chk(stateCode == 8'h7E, "R11 register start enters transfer", stateCode, 8'h7E);
    waitIdle("R11 resume");
    chk(bufDoneCount == 8'h00, "R11 counter unchanged", bufDoneCount, 8'h00);
    chk(irqCnt == 1, "R10 irq after resume", irqCnt, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule